// File: doc/BRIEF.md
# Flash Byte-Program Command Sequencer

This block sits between a CPU bus and a small on-chip flash array modelled as registers. Software programs one byte by making two bus writes to the same array address. The first write carries the program command code 0x40 and the second carries the data byte. Once the pair is accepted, the block runs a timed auto-program pass. That pass clears bits in the stored byte, waits a fixed number of cycles, and then compares the stored byte with the requested data.

A status register shows a ready/busy flag and a result flag. Software either polls the status register or enables a one-cycle completion interrupt. Writes to the program-ROM blocks are blocked by per-block lock bits. Writes to the four data blocks are blocked by per-block rewrite-disable bits. A refused command leaves the array untouched and sets the result flag.

Address map:
- The array takes data blocks A–D first, each `DBLK_BYTES` long, so with the defaults addresses 0x00–0x3F.
- The `NUM_PBLK` program-ROM blocks follow, each `PBLK_BYTES` long, so with the defaults addresses 0x40–0xBF.
- Array addresses past the end are unmapped.

Top module: `flash_byte_prog`

## Requirements
- R1: After reset the status register reads 0x80 (ready set, error clear), `irq_ready` is 0, every array byte reads 0xFF, and unmapped array addresses read 0x00.
- R2: A write of 0x40 to array address X followed by a data write to the same X starts programming, and the byte at X becomes the old value ANDed with the data.
- R3: Status bit 7 (ready) reads 0 for exactly `PROG_CYCLES` clock cycles after the cycle that accepts the data write, then reads 1.
- R4: At completion, status bit 4 (error) is 0 when the stored byte equals the requested data and 1 otherwise; an accepted command clears it at start.
- R5: A data write to an address other than the armed one, or a command to an unmapped address, is refused. Ready stays 1, error becomes 1, and the array is unchanged.
- R6: A first-cycle array write whose value is not 0x40 is refused with error set, and nothing is programmed.
- R7: When the interrupt-enable bit (register offset 1, bit 0) is 1, `irq_ready` is high for exactly one cycle as ready returns to 1. When that bit is 0, `irq_ready` stays low.
- R8: Lock register (offset 2) bit k set refuses program commands to program-ROM block k (with the defaults, address 0x40+32k..); unlocked blocks still program.
- R9: Rewrite-disable register (offset 3) bit j set refuses program commands to data block j (j=0..3 for A..D, 16 bytes each); other blocks still program.
- R10: Array writes made while ready is 0 are ignored: they neither modify the array nor arm a command. The status register reads correctly while busy.
- R11: Register space is selected by the top address bit; offsets 1–3 read back the written enable, lock and disable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW+1 (9) | Top bit selects register space; low bits are the array address or register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_ready | output | 1 | One-cycle completion pulse when enabled |

## Verification
The hardest case to reach from the ports is the bus activity that lands inside the busy window. A valid command pair and a stray array write must both arrive while the auto-program timer is still counting. Afterwards, a follow-up non-command write must be shown to be refused rather than completing an armed command.

The stimulus starts a program pass and immediately issues a fake command pair and an overwrite of the target byte, all within the 16-cycle window. It then sends one lone data write, so that any wrongly captured arming would surface as a changed byte. Verify failure needs a byte programmed twice with data whose cleared bits conflict, which the vector table sets up by chaining commands to one address.

// File: rtl/flash_byte_prog.sv
module flash_byte_prog #(
  parameter int PROG_CYCLES = 16,
  parameter int DBLK_BYTES  = 16,
  parameter int PBLK_BYTES  = 32,
  parameter int NUM_PBLK    = 4,
  parameter logic [7:0] CMD_PROGRAM = 8'h40,
  localparam int DATA_BYTES  = 4 * DBLK_BYTES,
  localparam int ARRAY_BYTES = DATA_BYTES + NUM_PBLK * PBLK_BYTES,
  localparam int AW = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW:0]   bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_we,
  output logic [7:0]    bus_rdata,
  output logic          irq_ready
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam int PW = $clog2(NUM_PBLK);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_BUSY} st_t;

  st_t                 st;
  logic [AW-1:0]       arm_addr;
  logic [7:0]          tgt_data;
  logic [CW-1:0]       cnt;
  logic                err, ie, irq_q;
  logic [NUM_PBLK-1:0] lock_q;
  logic [3:0]          wp_q;
  logic [7:0]          mem [ARRAY_BYTES];

  wire          reg_sel  = bus_addr[AW];
  wire [AW-1:0] a        = bus_addr[AW-1:0];
  wire          arr_wr   = bus_we && !reg_sel;
  wire          in_range = {1'b0, a} < (AW+1)'(ARRAY_BYTES);
  wire          is_data  = a < AW'(DATA_BYTES);
  wire [1:0]    dblk     = 2'(a / AW'(DBLK_BYTES));
  wire [PW-1:0] pblk     = PW'((a - AW'(DATA_BYTES)) / AW'(PBLK_BYTES));
  wire          blocked  = !in_range || (is_data ? wp_q[dblk] : lock_q[pblk]);
  wire          ready    = (st != S_BUSY);
  wire [7:0]    status   = {ready, 2'b00, err, 4'b0000};

  assign irq_ready = irq_q;

  always_comb begin
    bus_rdata = 8'h00;
    if (reg_sel) begin
      case (a[1:0])
        2'd0:    bus_rdata = status;
        2'd1:    bus_rdata = {7'b0, ie};
        2'd2:    bus_rdata = {{(8-NUM_PBLK){1'b0}}, lock_q};
        default: bus_rdata = {4'b0, wp_q};
      endcase
    end else if (in_range) begin
      bus_rdata = mem[a];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      arm_addr <= '0;
      tgt_data <= 8'h00;
      cnt      <= '0;
      err      <= 1'b0;
      ie       <= 1'b0;
      irq_q    <= 1'b0;
      lock_q   <= '0;
      wp_q     <= '0;
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      irq_q <= 1'b0;
      if (bus_we && reg_sel) begin
        case (a[1:0])
          2'd1:    ie     <= bus_wdata[0];
          2'd2:    lock_q <= bus_wdata[NUM_PBLK-1:0];
          2'd3:    wp_q   <= bus_wdata[3:0];
          default: ;
        endcase
      end
      case (st)
        S_IDLE: if (arr_wr) begin
          if (bus_wdata == CMD_PROGRAM) begin
            st       <= S_ARMED;
            arm_addr <= a;
          end else begin
            err <= 1'b1;
          end
        end
        S_ARMED: if (arr_wr) begin
          if (a == arm_addr && !blocked) begin
            st       <= S_BUSY;
            tgt_data <= bus_wdata;
            cnt      <= CW'(PROG_CYCLES - 1);
            err      <= 1'b0;
            mem[a]   <= mem[a] & bus_wdata;
          end else begin
            st  <= S_IDLE;
            err <= 1'b1;
          end
        end
        S_BUSY: begin
          if (cnt == '0) begin
            st    <= S_IDLE;
            err   <= (mem[arm_addr] != tgt_data);
            irq_q <= ie;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW:0] busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n)      busy_len <= '0;
    else if (!ready) busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> busy_len == (CW+1)'(PROG_CYCLES));

  p_start_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(st == S_ARMED && arr_wr && a == arm_addr));

  p_verify_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> err == (mem[arm_addr] != tgt_data));

  p_mismatch_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED && arr_wr && a != arm_addr) |=> (ready && err && st == S_IDLE));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |=> !irq_ready);

  p_irq_on_finish_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> irq_ready == $past(ie));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && arr_wr && in_range) |=> mem[$past(a)] == $past(mem[a]));
endmodule

// File: tb/sim_flash_byte_prog.sv
module sim_flash_byte_prog;
  localparam int P = 16;
  localparam logic [8:0] R_STAT = 9'h100;
  localparam logic [8:0] R_IE   = 9'h101;
  localparam logic [8:0] R_LOCK = 9'h102;
  localparam logic [8:0] R_WP   = 9'h103;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_byte_prog #(.PROG_CYCLES(P)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .irq_ready(irq));

  // code, addr1, addr2, data, accepted, expected byte at addr2, expected error
  localparam logic [55:0] VEC [8] = '{
    {8'h40, 8'h10, 8'h10, 8'h5A, 8'h01, 8'h5A, 8'h00},
    {8'h40, 8'h50, 8'h50, 8'h00, 8'h01, 8'h00, 8'h00},
    {8'h40, 8'h20, 8'h21, 8'h33, 8'h00, 8'hFF, 8'h01},
    {8'h40, 8'h10, 8'h10, 8'h50, 8'h01, 8'h50, 8'h00},
    {8'h40, 8'h10, 8'h10, 8'hA5, 8'h01, 8'h00, 8'h01},
    {8'h41, 8'h30, 8'h30, 8'h12, 8'h00, 8'hFF, 8'h01},
    {8'h40, 8'hC5, 8'hC5, 8'h11, 8'h00, 8'h00, 8'h01},
    {8'h40, 8'hBF, 8'hBF, 8'h7E, 8'h01, 8'h7E, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic cmd(input logic [7:0] code, input logic [7:0] a1, input logic [7:0] a2,
                     input logic [7:0] d, output int n, output logic irq_end);
    wr({1'b0, a1}, code);
    wr({1'b0, a2}, d);
    addr = R_STAT; #1;
    n = 0;
    while (rdata[7] == 1'b0 && n < 1000) begin
      @(negedge clk); #1; n++;
    end
    irq_end = irq;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    logic ie_seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(R_STAT, v);     check("R1 status", v, 8'h80);
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(9'h000, v);     check("R1 erased", v, 8'hFF);
    rd(9'h0BF, v);     check("R1 erased last", v, 8'hFF);
    rd(9'h0C0, v);     check("R1 unmapped", v, 8'h00);

    for (int i = 0; i < 8; i++) begin
      cmd(VEC[i][55:48], VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], n, ie_seen);
      check($sformatf("R3 busy length vec%0d", i), 8'(n), VEC[i][16] ? 8'(P) : 8'd0);
      check($sformatf("R7 no irq when disabled vec%0d", i), {7'b0, ie_seen}, 8'h00);
      rd(R_STAT, v);
      check($sformatf("R4 R5 R6 error vec%0d", i), v, {1'b1, 2'b0, VEC[i][0], 4'b0});
      rd({1'b0, VEC[i][39:32]}, v);
      check($sformatf("R2 stored byte vec%0d", i), v, VEC[i][15:8]);
    end
    rd(9'h020, v); check("R5 armed address untouched", v, 8'hFF);

    wr(R_IE, 8'h01);
    rd(R_IE, v); check("R11 ie readback", v, 8'h01);
    cmd(8'h40, 8'h11, 8'h11, 8'h3C, n, ie_seen);
    check("R7 irq at completion", {7'b0, ie_seen}, 8'h01);
    @(negedge clk); #1;
    check("R7 irq single cycle", {7'b0, irq}, 8'h00);
    wr(R_IE, 8'h00);

    wr(R_LOCK, 8'h02);
    rd(R_LOCK, v); check("R11 lock readback", v, 8'h02);
    cmd(8'h40, 8'h65, 8'h65, 8'h00, n, ie_seen);
    check("R8 locked block refused", 8'(n), 8'd0);
    rd(R_STAT, v); check("R8 error on lock", v, 8'h90);
    rd(9'h065, v); check("R8 locked byte kept", v, 8'hFF);
    cmd(8'h40, 8'h45, 8'h45, 8'h0F, n, ie_seen);
    rd(9'h045, v); check("R8 unlocked block programs", v, 8'h0F);
    wr(R_LOCK, 8'h00);

    wr(R_WP, 8'h04);
    rd(R_WP, v); check("R11 disable readback", v, 8'h04);
    cmd(8'h40, 8'h28, 8'h28, 8'h00, n, ie_seen);
    rd(R_STAT, v); check("R9 error on disabled block", v, 8'h90);
    rd(9'h028, v); check("R9 disabled byte kept", v, 8'hFF);
    cmd(8'h40, 8'h38, 8'h38, 8'h81, n, ie_seen);
    rd(9'h038, v); check("R9 other block programs", v, 8'h81);
    wr(R_WP, 8'h00);

    wr(9'h03A, 8'h40);
    wr(9'h03A, 8'h0F);
    wr(9'h03B, 8'h40);
    wr(9'h03B, 8'h00);
    wr(9'h03A, 8'h00);
    rd(R_STAT, v); check("R10 status while busy", v, 8'h00);
    n = 0;
    while (v[7] == 1'b0 && n < 100) begin rd(R_STAT, v); n++; end
    check("R10 completes clean", v, 8'h80);
    rd(9'h03A, v); check("R10 target not overwritten", v, 8'h0F);
    rd(9'h03B, v); check("R10 busy command ignored", v, 8'hFF);
    wr(9'h03B, 8'h00);
    rd(R_STAT, v); check("R10 not left armed", v, 8'h90);
    rd(9'h03B, v); check("R10 byte still erased", v, 8'hFF);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(R_STAT, v); check("R1 status after reset", v, 8'h80);
    rd(9'h010, v); check("R1 array erased after reset", v, 8'hFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule